// File: doc/BRIEF.md
# Controller and Status Register Block

This block sits on the processor's register bus and holds a few simple controls. It has a strobe line shared by both controller ports, a general-purpose output byte, and a ROM access-speed select. It also answers reads of several status registers. A read returns the live flags in their fixed bit positions. Every bit position that carries no flag is filled from the last byte seen on the data bus (the open-bus byte). A read of any address that the block does not decode returns that byte unchanged.

Writes are taken on the rising clock edge when `wr` is high. Read data is combinational from `addr` and the live inputs, so the bus can sample it in the same cycle. The block watches bit 7 of the output port. When a write drives that bit from 1 to 0, the block issues a registered single-cycle pulse that tells the beam counters to latch their values.

The horizontal blanking flag is set inside a fixed counter window, and so is the vertical blanking flag. The vertical window starts later when overscan is on. All register offsets, counter widths, window edges and the version constant are parameters.

Top module: `ctrl_status_regs`

## Requirements
- R1: A write to offset 0 (controller strobe) sets `pad_strobe` to write bit 0 on the next clock. A write to offset 1 leaves `pad_strobe` unchanged. Reset clears `pad_strobe` to 0.
- R2: A read of offset 0 returns `open_bus[7:2]` in bits 7..2 and `pad1_data` in bits 1..0.
- R3: A read of offset 1 returns `open_bus[7:5]` in bits 7..5, ones in bits 4..2, and `pad2_data` in bits 1..0.
- R4: A write to offset 2 loads `port_out` with the write byte on the next clock. A read of offset 2 returns the stored byte. Reset sets `port_out` to 8'hFF.
- R5: A write to offset 2 while `port_out[7]` is 1 with write bit 7 equal to 0 raises `cnt_latch` for exactly the one cycle after that clock edge. No other write raises it.
- R6: A read of offset 6 (blanking status) has bit 6 set exactly when `hcount` <= 2 or `hcount` >= 1096.
- R7: Bit 7 of the offset 6 read is set exactly when `vcount` >= 225 with `overscan` low, or when `vcount` >= 240 with `overscan` high.
- R8: Bit 0 of the offset 6 read equals `autopoll_busy`. Bits 5..1 come from `open_bus[5:1]`.
- R9: A read of offset 4 returns `nmi_flag` in bit 7, `open_bus[6:4]` in bits 6..4, and the version constant (default 4'h2) in bits 3..0.
- R10: A read of offset 5 returns `irq_flag` in bit 7 and `open_bus[6:0]` in bits 6..0.
- R11: A write to offset 3 sets `rom_cycles` to 6 when write bit 0 is 1 and to 8 when it is 0. Reset gives 8. Reading offset 3 returns the open-bus byte.
- R12: Reads of offset 3 and of offsets 7..15 return `open_bus` unchanged. Writes to those offsets change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wr | input | 1 | Write enable, taken on the rising edge |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational |
| open_bus | input | 8 | Last byte seen on the data bus |
| pad1_data | input | 2 | Serial data from controller port 1 |
| pad2_data | input | 2 | Serial data from controller port 2 |
| hcount | input | 11 | Horizontal beam counter |
| vcount | input | 9 | Vertical beam counter |
| overscan | input | 1 | Overscan mode; moves the vertical blanking start |
| autopoll_busy | input | 1 | Automatic controller poll in progress |
| nmi_flag | input | 1 | NMI pending flag |
| irq_flag | input | 1 | IRQ pending flag |
| pad_strobe | output | 1 | Latch line to both controller ports |
| cnt_latch | output | 1 | One-cycle counter-latch pulse |
| port_out | output | 8 | General-purpose output byte |
| rom_cycles | output | 4 | ROM access length in cycles (6 or 8) |

## Verification
The bench builds the block with its default parameters. With those values the 11-bit horizontal counter and 9-bit vertical counter cover both edges of every blanking window: 2/3 and 1095/1096 horizontally, 224/225 and 239/240 vertically. The 4-bit offset also reaches nine undecoded addresses for the open-bus cases. Random offsets and write bytes repeatedly toggle output-port bit 7. This exercises falling edges, rising edges and repeated writes of 0 for the counter-latch pulse.

// File: rtl/ctrl_status_regs.sv
module ctrl_status_regs #(
  parameter int       ADDR_W    = 4,
  parameter int       H_W       = 11,
  parameter int       V_W       = 9,
  parameter int       HB_END    = 2,
  parameter int       HB_START  = 1096,
  parameter int       VB_NORM   = 225,
  parameter int       VB_OVER   = 240,
  parameter int       ROM_SLOW  = 8,
  parameter int       ROM_FAST  = 6,
  parameter logic [3:0] VERSION = 4'h2,
  parameter int       A_JOY1    = 0,
  parameter int       A_JOY2    = 1,
  parameter int       A_PORT    = 2,
  parameter int       A_SPEED   = 3,
  parameter int       A_NMI     = 4,
  parameter int       A_IRQ     = 5,
  parameter int       A_BLANK   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        open_bus,
  input  logic [1:0]        pad1_data,
  input  logic [1:0]        pad2_data,
  input  logic [H_W-1:0]    hcount,
  input  logic [V_W-1:0]    vcount,
  input  logic              overscan,
  input  logic              autopoll_busy,
  input  logic              nmi_flag,
  input  logic              irq_flag,
  output logic              pad_strobe,
  output logic              cnt_latch,
  output logic [7:0]        port_out,
  output logic [3:0]        rom_cycles
);

  localparam logic [ADDR_W-1:0] AJ1 = ADDR_W'(A_JOY1);
  localparam logic [ADDR_W-1:0] AJ2 = ADDR_W'(A_JOY2);
  localparam logic [ADDR_W-1:0] APT = ADDR_W'(A_PORT);
  localparam logic [ADDR_W-1:0] ASP = ADDR_W'(A_SPEED);
  localparam logic [ADDR_W-1:0] ANM = ADDR_W'(A_NMI);
  localparam logic [ADDR_W-1:0] AIQ = ADDR_W'(A_IRQ);
  localparam logic [ADDR_W-1:0] ABL = ADDR_W'(A_BLANK);
  localparam logic [H_W-1:0]    H_LO = H_W'(HB_END);
  localparam logic [H_W-1:0]    H_HI = H_W'(HB_START);
  localparam logic [V_W-1:0]    V_N  = V_W'(VB_NORM);
  localparam logic [V_W-1:0]    V_O  = V_W'(VB_OVER);

  logic wr_joy, wr_port, wr_speed, port_fall;
  logic hblank, vblank;

  assign wr_joy    = wr && (addr == AJ1);
  assign wr_port   = wr && (addr == APT);
  assign wr_speed  = wr && (addr == ASP);
  assign port_fall = wr_port && port_out[7] && !wdata[7];

  assign hblank = (hcount <= H_LO) || (hcount >= H_HI);
  assign vblank = vcount >= (overscan ? V_O : V_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_strobe <= 1'b0;
      port_out   <= 8'hFF;
      cnt_latch  <= 1'b0;
      rom_cycles <= 4'(ROM_SLOW);
    end else begin
      cnt_latch <= port_fall;
      if (wr_joy)   pad_strobe <= wdata[0];
      if (wr_port)  port_out   <= wdata;
      if (wr_speed) rom_cycles <= wdata[0] ? 4'(ROM_FAST) : 4'(ROM_SLOW);
    end
  end

  always_comb begin
    unique case (addr)
      AJ1:     rdata = {open_bus[7:2], pad1_data};
      AJ2:     rdata = {open_bus[7:5], 3'b111, pad2_data};
      APT:     rdata = port_out;
      ANM:     rdata = {nmi_flag, open_bus[6:4], VERSION};
      AIQ:     rdata = {irq_flag, open_bus[6:0]};
      ABL:     rdata = {vblank, hblank, open_bus[5:1], autopoll_busy};
      default: rdata = open_bus;
    endcase
  end

endmodule

// File: rtl/ctrl_status_chk.sv
module ctrl_status_chk #(
  parameter int ADDR_W  = 4,
  parameter int A_JOY1  = 0,
  parameter int A_JOY2  = 1,
  parameter int A_PORT  = 2,
  parameter int A_SPEED = 3,
  parameter int A_BLANK = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic [7:0]        rdata,
  input logic [7:0]        open_bus,
  input logic [1:0]        pad1_data,
  input logic [1:0]        pad2_data,
  input logic              pad_strobe,
  input logic              cnt_latch,
  input logic [7:0]        port_out,
  input logic [3:0]        rom_cycles
);

  p_strobe_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_W'(A_JOY1)) |=> $stable(pad_strobe));

  p_joy1_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(A_JOY1) |-> rdata == {open_bus[7:2], pad1_data});

  p_joy2_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(A_JOY2) |-> rdata == {open_bus[7:5], 3'b111, pad2_data});

  p_port_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_W'(A_PORT)) |=> $stable(port_out));

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_latch |-> ($past(port_out[7]) && !port_out[7]));

  p_pulse_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_out[7]) |-> cnt_latch);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_latch |=> !cnt_latch);

  p_rom_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cycles == 4'd6 || rom_cycles == 4'd8);

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_SPEED) || addr > ADDR_W'(A_BLANK)) |-> rdata == open_bus);

endmodule

bind ctrl_status_regs ctrl_status_chk #(
  .ADDR_W(ADDR_W), .A_JOY1(A_JOY1), .A_JOY2(A_JOY2),
  .A_PORT(A_PORT), .A_SPEED(A_SPEED), .A_BLANK(A_BLANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rdata(rdata),
  .open_bus(open_bus), .pad1_data(pad1_data), .pad2_data(pad2_data),
  .pad_strobe(pad_strobe), .cnt_latch(cnt_latch), .port_out(port_out),
  .rom_cycles(rom_cycles)
);

// File: tb/tb_ctrl_status_regs.sv
`timescale 1ns/1ps
module tb_ctrl_status_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0, rdata, open_bus = '0, port_out;
  logic [1:0] pad1_data = '0, pad2_data = '0;
  logic [10:0] hcount = '0;
  logic [8:0] vcount = '0;
  logic overscan = 0, autopoll_busy = 0, nmi_flag = 0, irq_flag = 0;
  logic pad_strobe, cnt_latch;
  logic [3:0] rom_cycles;

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_strobe = 0, m_pulse = 0;
  logic [7:0] m_port = 8'hFF;
  logic [3:0] m_rom = 4'd8;

  always #2.5 clk = ~clk;

  ctrl_status_regs dut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] a);
    case (a)
      4'd0: return "R2"; 4'd1: return "R3"; 4'd2: return "R4";
      4'd4: return "R9"; 4'd5: return "R10"; 4'd6: return "R6/R7/R8";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic hb, vb;
    hb = (hcount <= 2) || (hcount >= 1096);
    vb = overscan ? (vcount >= 240) : (vcount >= 225);
    case (a)
      4'd0: return {open_bus[7:2], pad1_data};
      4'd1: return {open_bus[7:5], 3'b111, pad2_data};
      4'd2: return m_port;
      4'd4: return {nmi_flag, open_bus[6:4], 4'h2};
      4'd5: return {irq_flag, open_bus[6:0]};
      4'd6: return {vb, hb, open_bus[5:1], autopoll_busy};
      default: return open_bus;
    endcase
  endfunction

  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = w; wdata = d;
    #1;
    chk(tag(a), rdata, exp_rd(a));
    m_pulse = w && a == 4'd2 && m_port[7] && !d[7];
    if (w) begin
      if (a == 4'd0) m_strobe = d[0];
      if (a == 4'd2) m_port = d;
      if (a == 4'd3) m_rom = d[0] ? 4'd6 : 4'd8;
    end
    @(posedge clk); #1;
    wr = 0;
    chk("R1", {7'd0, pad_strobe}, {7'd0, m_strobe});
    chk("R4", port_out, m_port);
    chk("R5", {7'd0, cnt_latch}, {7'd0, m_pulse});
    chk("R11", {4'd0, rom_cycles}, {4'd0, m_rom});
  endtask

  task automatic rand_inputs();
    open_bus = 8'($urandom); pad1_data = 2'($urandom); pad2_data = 2'($urandom);
    hcount = 11'($urandom_range(0, 1363)); vcount = 9'($urandom_range(0, 261));
    overscan = 1'($urandom); autopoll_busy = 1'($urandom);
    nmi_flag = 1'($urandom); irq_flag = 1'($urandom);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset", port_out, 8'hFF);
    chk("R11 reset", {4'd0, rom_cycles}, 8'd8);
    chk("R1 reset", {7'd0, pad_strobe}, 8'd0);
    chk("R5 reset", {7'd0, cnt_latch}, 8'd0);
    @(negedge clk); rst_n = 1;

    open_bus = 8'hA5;
    step(4'd0, 1, 8'h01);
    step(4'd1, 1, 8'h00);
    step(4'd0, 1, 8'hFE);
    step(4'd1, 1, 8'hFF);
    step(4'd2, 1, 8'h7F);
    step(4'd2, 1, 8'h00);
    step(4'd2, 1, 8'h80);
    step(4'd2, 1, 8'h80);
    step(4'd3, 1, 8'h01);
    step(4'd3, 0, 8'h00);
    step(4'd3, 1, 8'h00);
    for (int a = 7; a < 16; a++) step(4'(a), 1, 8'h5A);

    foreach (hcount[i]) begin end
    for (int k = 0; k < 4; k++) begin
      hcount = (k == 0) ? 11'd2 : (k == 1) ? 11'd3 : (k == 2) ? 11'd1095 : 11'd1096;
      step(4'd6, 0, 8'h00);
    end
    for (int os = 0; os < 2; os++) begin
      overscan = 1'(os);
      for (int k = 0; k < 4; k++) begin
        vcount = (k == 0) ? 9'd224 : (k == 1) ? 9'd225 : (k == 2) ? 9'd239 : 9'd240;
        step(4'd6, 0, 8'h00);
      end
    end
    nmi_flag = 1; irq_flag = 1; step(4'd4, 0, 0); step(4'd5, 0, 0);
    nmi_flag = 0; irq_flag = 0; step(4'd4, 0, 0); step(4'd5, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      rand_inputs();
      step(4'($urandom_range(0, 15)), 1'($urandom), 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule